// File: doc/BRIEF.md
# Hardware Trap Priority Controller

This block sits beside a CPU core and turns exception strobes into trap services. Reset-cause lines, a non-maskable interrupt pin, stack limit detectors and five fault strobes each set their own bit in a sticky trap flag register and raise a pending request. A fixed three-class priority scheme picks the most urgent pending request. If that request outranks the service level now in progress, the block pulses a trap-taken strobe and hands the fetch unit a trap number and a vector address. The vector address is the trap number times four.

Nested services are tracked by a small stack of saved levels. A trap of higher class preempts a running service. A request of equal or lower class waits until return-from-trap strobes bring the level down far enough. While any hardware service runs, ordinary interrupts are blocked. Software traps carry any 7-bit number and leave the service level unchanged. The five fault sources share one vector, so software reads the flag register to learn which fault occurred and writes zeros to clear the bits it has handled.

Top module: `trap_prio_ctrl`

## Requirements
- R1: After reset, trap_take_o, trap_num_o, trap_vec_o, svc_lvl_o, irq_block_o and flags_o are all zero.
- R2: A strobe sampled at a clock edge sets its flag bit, visible after that edge. Flag bit positions: 0 power-on reset cause, 1 software reset cause, 2 watchdog reset cause, 3 NMI, 4 stack overflow, 5 stack underflow, 6 undefined opcode, 7 protection fault, 8 illegal operand, 9 illegal instruction fetch, 10 illegal bus access.
- R3: A flag bit stays set until a flag write carries 0 in that bit position. A 1 in the write data leaves the bit unchanged. A strobe in the same cycle as a clearing write leaves the bit set.
- R4: A hardware strobe sampled at edge k becomes pending. If it outranks the current level, trap_take_o is high for the cycle after edge k+1, with trap_num_o and trap_vec_o valid there.
- R5: Any reset-cause request is serviced as trap number 0x00, vector 0x0000, level 3. All pending reset causes are consumed by one service.
- R6: NMI, stack overflow and stack underflow are serviced at level 2 as numbers 0x02, 0x04 and 0x06 (vectors 0x08, 0x10, 0x18). When several are pending, NMI goes first, then overflow, then underflow, one per service.
- R7: Every fault strobe is serviced at level 1 as number 0x0A, vector 0x28. One service consumes all pending faults.
- R8: A pending request is taken only when its level is strictly above svc_lvl_o. Otherwise it stays pending until returns lower the level below it.
- R9: A return strobe restores the level that was active before the latest hardware service and takes no trap in that cycle. At level 0 a return has no effect.
- R10: irq_block_o is high exactly while svc_lvl_o is nonzero.
- R11: A software trap strobe is accepted only at level 0 and only if no hardware trap is taken at that edge. It gives trap_take_o after that same edge, trap_num_o equal to the requested number, trap_vec_o equal to the number times four, and svc_lvl_o stays 0. Otherwise it is dropped.
- R12: A hardware service never issues a trap number in the range 0x0B to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_src_i | input | 3 | Reset-cause strobes (power-on, software, watchdog) |
| nmi_i | input | 1 | Non-maskable interrupt strobe |
| stk_ovf_i | input | 1 | Stack overflow strobe |
| stk_unf_i | input | 1 | Stack underflow strobe |
| fault_b_i | input | 5 | Fault strobes (undefined opcode, protection, operand, instruction fetch, bus) |
| sw_trap_i | input | 1 | Software trap request strobe |
| sw_num_i | input | 7 | Software trap number |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| flag_wr_i | input | 1 | Flag register write enable |
| flag_wdata_i | input | 11 | Flag write data; zeros clear bits |
| trap_take_o | output | 1 | One-cycle trap-taken pulse |
| trap_vec_o | output | ADDR_W | Vector address of the last trap taken |
| trap_num_o | output | 7 | Trap number of the last trap taken |
| svc_lvl_o | output | 2 | Current service level (0 to 3) |
| irq_block_o | output | 1 | Blocks ordinary interrupts |
| flags_o | output | 11 | Trap flag register |

## Verification
The bench attacks simultaneous arrivals within Class A. A design with the order inverted would vector to 0x18 before 0x08. It fires requests of equal or lower class during a service. A design that compared with "greater or equal" would take them at once and push a second entry, so the level would not unwind correctly on return. It combines return strobes with pending work and software traps at nonzero levels. A wrong design would take a trap in the return cycle or let a software trap through. Flag writes that coincide with new strobes catch a clear that wins over a set.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int NUM_FLAGS = 11;
   localparam int RST_LO    = 0;
   localparam int RST_CNT   = 3;
   localparam int CLA_LO    = 3;
   localparam int CLA_CNT   = 3;
   localparam int CLB_LO    = 6;
   localparam int CLB_CNT   = 5;
   localparam int NUM_W     = 7;

   localparam logic [NUM_W-1:0] NUM_RESET  = 7'h00;
   localparam logic [NUM_W-1:0] NUM_CLA0   = 7'h02;
   localparam logic [NUM_W-1:0] NUM_CLASSB = 7'h0A;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_B    = 2'd1,
      LVL_A    = 2'd2,
      LVL_RST  = 2'd3
   } lvl_e;
endpackage

// File: rtl/trap_flags.sv
module trap_flags
   import trap_pkg::*;
#(
   parameter int NF = NUM_FLAGS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] consume_i,
   input  logic          wr_i,
   input  logic [NF-1:0] wdata_i,
   output logic [NF-1:0] flags_o,
   output logic [NF-1:0] pend_o
);
   logic [NF-1:0] flags_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         pend_q  <= '0;
      end else begin
         flags_q <= (wr_i ? (flags_q & wdata_i) : flags_q) | set_i;
         pend_q  <= (pend_q & ~consume_i) | set_i;
      end
   end

   assign flags_o = flags_q;
   assign pend_o  = pend_q;

   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> (($past(flags_q) & ~flags_q) == '0));

   p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/trap_arb.sv
module trap_arb
   import trap_pkg::*;
(
   input  logic [NUM_FLAGS-1:0] pend_i,
   output lvl_e                 req_lvl_o,
   output logic [NUM_W-1:0]     req_num_o,
   output logic [NUM_FLAGS-1:0] consume_o
);
   always_comb begin
      req_lvl_o = LVL_NONE;
      req_num_o = '0;
      consume_o = '0;
      if (|pend_i[CLB_LO +: CLB_CNT]) begin
         req_lvl_o = LVL_B;
         req_num_o = NUM_CLASSB;
         consume_o[CLB_LO +: CLB_CNT] = '1;
      end
      if (|pend_i[CLA_LO +: CLA_CNT]) begin
         req_lvl_o = LVL_A;
         consume_o = '0;
         for (int i = CLA_CNT - 1; i >= 0; i--) begin
            if (pend_i[CLA_LO + i]) begin
               req_num_o = NUM_CLA0 + NUM_W'(2 * i);
               consume_o = '0;
               consume_o[CLA_LO + i] = 1'b1;
            end
         end
      end
      if (|pend_i[RST_LO +: RST_CNT]) begin
         req_lvl_o = LVL_RST;
         req_num_o = NUM_RESET;
         consume_o = '0;
         consume_o[RST_LO +: RST_CNT] = '1;
      end
   end
endmodule

// File: rtl/trap_lvl_stack.sv
module trap_lvl_stack #(
   parameter int DEPTH = 3,
   parameter int LW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [LW-1:0] push_val_i,
   output logic [LW-1:0] top_o
);
   logic [LW-1:0] ent_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (push_i) begin
         ent_q[0] <= push_val_i;
         for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
      end else if (pop_i) begin
         for (int i = 0; i < DEPTH - 1; i++) ent_q[i] <= ent_q[i+1];
         ent_q[DEPTH-1] <= '0;
      end
   end

   assign top_o = ent_q[0];

   p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl
   import trap_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int NEST_DEPTH = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RST_CNT-1:0]   rst_src_i,
   input  logic                 nmi_i,
   input  logic                 stk_ovf_i,
   input  logic                 stk_unf_i,
   input  logic [CLB_CNT-1:0]   fault_b_i,
   input  logic                 sw_trap_i,
   input  logic [NUM_W-1:0]     sw_num_i,
   input  logic                 trap_ret_i,
   input  logic                 flag_wr_i,
   input  logic [NUM_FLAGS-1:0] flag_wdata_i,
   output logic                 trap_take_o,
   output logic [ADDR_W-1:0]    trap_vec_o,
   output logic [NUM_W-1:0]     trap_num_o,
   output logic [1:0]           svc_lvl_o,
   output logic                 irq_block_o,
   output logic [NUM_FLAGS-1:0] flags_o
);
   localparam int VEC_BITS = NUM_W + 2;

   generate
      if (ADDR_W < VEC_BITS) begin : g_bad_addr
         $error("ADDR_W too narrow for vector table");
      end
      if (NEST_DEPTH < 3) begin : g_bad_depth
         $error("NEST_DEPTH must hold three nested levels");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] set_vec, pend, consume_mask, consume;
   lvl_e                 req_lvl, cur_lvl_q;
   logic [NUM_W-1:0]     req_num, num_q;
   logic [1:0]           stk_top;
   logic                 hw_go, sw_go, take_q;

   assign set_vec = {fault_b_i, stk_unf_i, stk_ovf_i, nmi_i, rst_src_i};

   trap_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .consume_i(consume),
      .wr_i(flag_wr_i), .wdata_i(flag_wdata_i),
      .flags_o(flags_o), .pend_o(pend)
   );

   trap_arb u_arb (
      .pend_i(pend), .req_lvl_o(req_lvl),
      .req_num_o(req_num), .consume_o(consume_mask)
   );

   assign hw_go   = !trap_ret_i && (req_lvl > cur_lvl_q);
   assign sw_go   = !trap_ret_i && !hw_go && sw_trap_i && (cur_lvl_q == LVL_NONE);
   assign consume = hw_go ? consume_mask : '0;

   trap_lvl_stack #(.DEPTH(NEST_DEPTH), .LW(2)) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(hw_go), .pop_i(trap_ret_i),
      .push_val_i(cur_lvl_q), .top_o(stk_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q    <= 1'b0;
         num_q     <= '0;
         cur_lvl_q <= LVL_NONE;
      end else begin
         take_q <= hw_go | sw_go;
         if (hw_go) begin
            num_q     <= req_num;
            cur_lvl_q <= req_lvl;
         end else if (sw_go) begin
            num_q <= sw_num_i;
         end else if (trap_ret_i) begin
            cur_lvl_q <= lvl_e'(stk_top);
         end
      end
   end

   assign trap_take_o = take_q;
   assign trap_num_o  = num_q;
   assign trap_vec_o  = {{(ADDR_W-VEC_BITS){1'b0}}, num_q, 2'b00};
   assign svc_lvl_o   = cur_lvl_q;
   assign irq_block_o = (cur_lvl_q != LVL_NONE);

   p_lvl_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take_o && svc_lvl_o != 2'd0) |-> (svc_lvl_o > $past(svc_lvl_o)));

   p_ret_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ret_i |=> !trap_take_o);

   p_sw_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trap_i && svc_lvl_o != 2'd0) |=> (!trap_take_o || svc_lvl_o > $past(svc_lvl_o)));

   p_no_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take_o && svc_lvl_o != 2'd0) |-> !(trap_num_o >= 7'h0B && trap_num_o <= 7'h0F));

   p_block_on_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take_o && svc_lvl_o != 2'd0) |-> irq_block_o);
endmodule

// File: tb/sim_trap_prio_ctrl.sv
module sim_trap_prio_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rst_src_i = '0;
   logic        nmi_i = 1'b0, stk_ovf_i = 1'b0, stk_unf_i = 1'b0;
   logic [4:0]  fault_b_i = '0;
   logic        sw_trap_i = 1'b0;
   logic [6:0]  sw_num_i = '0;
   logic        trap_ret_i = 1'b0, flag_wr_i = 1'b0;
   logic [10:0] flag_wdata_i = '0;
   logic        trap_take_o;
   logic [23:0] trap_vec_o;
   logic [6:0]  trap_num_o;
   logic [1:0]  svc_lvl_o;
   logic        irq_block_o;
   logic [10:0] flags_o;

   int n_chk = 0, n_fail = 0, n_cyc = 0;

   logic [10:0] m_pend = '0, m_flags = '0;
   int          m_lvl = 0;
   int          m_stk [3] = '{0, 0, 0};
   logic        m_take = 1'b0;
   logic [6:0]  m_num = '0;

   trap_prio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src_i), .nmi_i(nmi_i),
      .stk_ovf_i(stk_ovf_i), .stk_unf_i(stk_unf_i), .fault_b_i(fault_b_i),
      .sw_trap_i(sw_trap_i), .sw_num_i(sw_num_i), .trap_ret_i(trap_ret_i),
      .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
      .trap_take_o(trap_take_o), .trap_vec_o(trap_vec_o), .trap_num_o(trap_num_o),
      .svc_lvl_o(svc_lvl_o), .irq_block_o(irq_block_o), .flags_o(flags_o)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int lvl_of(input logic [10:0] p);
      if (|p[2:0]) return 3;
      if (|p[5:3]) return 2;
      if (|p[10:6]) return 1;
      return 0;
   endfunction

   function automatic logic [6:0] num_of(input logic [10:0] p);
      if (|p[2:0]) return 7'h00;
      if (p[3]) return 7'h02;
      if (p[4]) return 7'h04;
      if (p[5]) return 7'h06;
      return 7'h0A;
   endfunction

   function automatic logic [10:0] used_of(input logic [10:0] p);
      if (|p[2:0]) return 11'h007;
      if (p[3]) return 11'h008;
      if (p[4]) return 11'h010;
      if (p[5]) return 11'h020;
      return 11'h7C0;
   endfunction

   task automatic model_step(input logic [10:0] set, input bit sw, input logic [6:0] swn,
                             input bit ret, input bit wr, input logic [10:0] wd);
      int rl;
      rl = lvl_of(m_pend);
      m_take = 1'b0;
      if (ret) begin
         m_lvl = m_stk[0];
         m_stk[0] = m_stk[1]; m_stk[1] = m_stk[2]; m_stk[2] = 0;
      end else if (rl > m_lvl) begin
         m_stk[2] = m_stk[1]; m_stk[1] = m_stk[0]; m_stk[0] = m_lvl;
         m_lvl  = rl;
         m_num  = num_of(m_pend);
         m_take = 1'b1;
         m_pend = m_pend & ~used_of(m_pend);
      end else if (sw && m_lvl == 0) begin
         m_take = 1'b1;
         m_num  = swn;
      end
      m_pend = m_pend | set;
      if (wr) m_flags = m_flags & wd;
      m_flags = m_flags | set;
   endtask

   task automatic cyc(input logic [10:0] set, input bit sw = 0, input logic [6:0] swn = '0,
                      input bit ret = 0, input bit wr = 0, input logic [10:0] wd = '0);
      rst_src_i = set[2:0]; nmi_i = set[3]; stk_ovf_i = set[4]; stk_unf_i = set[5];
      fault_b_i = set[10:6]; sw_trap_i = sw; sw_num_i = swn; trap_ret_i = ret;
      flag_wr_i = wr; flag_wdata_i = wd;
      model_step(set, sw, swn, ret, wr, wd);
      @(negedge clk);
      n_cyc++;
      chk(trap_take_o == m_take, "R4 take strobe", int'(trap_take_o), int'(m_take));
      chk(int'(svc_lvl_o) == m_lvl, "R8 service level", int'(svc_lvl_o), m_lvl);
      chk(irq_block_o == (m_lvl != 0), "R10 irq block", int'(irq_block_o), int'(m_lvl != 0));
      chk(flags_o == m_flags, "R2 flags", int'(flags_o), int'(m_flags));
      chk(trap_num_o == m_num, "R6 trap number", int'(trap_num_o), int'(m_num));
      chk(trap_vec_o == {15'd0, m_num, 2'b00}, "R11 vector", int'(trap_vec_o), int'({m_num, 2'b00}));
      if (trap_take_o && svc_lvl_o != 0)
         chk(!(trap_num_o inside {[7'h0B:7'h0F]}), "R12 reserved", int'(trap_num_o), 10);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc('0);
   endtask

   task automatic fire(input logic [10:0] set, input string tag, input int en, input int ev, input int el);
      cyc(set);
      cyc('0);
      chk(trap_take_o == 1'b1, tag, int'(trap_take_o), 1);
      chk(int'(trap_num_o) == en, tag, int'(trap_num_o), en);
      chk(int'(trap_vec_o) == ev, tag, int'(trap_vec_o), ev);
      chk(int'(svc_lvl_o) == el, tag, int'(svc_lvl_o), el);
      cyc('0, .ret(1));
      chk(svc_lvl_o == 2'd0 && !trap_take_o, "R9 return to idle", int'(svc_lvl_o), 0);
      cyc('0, .wr(1), .wd('0));
   endtask

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk(trap_take_o == 0 && trap_num_o == 0 && trap_vec_o == 0 && svc_lvl_o == 0
          && irq_block_o == 0 && flags_o == 0, "R1 reset state", int'(flags_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      fire(11'h001, "R5 power-on cause", 0, 0, 3);
      fire(11'h002, "R5 software cause", 0, 0, 3);
      fire(11'h004, "R5 watchdog cause", 0, 0, 3);
      fire(11'h008, "R6 nmi", 2, 8, 2);
      fire(11'h010, "R6 stack overflow", 4, 16, 2);
      fire(11'h020, "R6 stack underflow", 6, 24, 2);
      for (int b = 0; b < 5; b++) fire(11'h040 << b, "R7 fault", 10, 40, 1);

      // R6 order: all three class-A at once
      cyc(11'h038); cyc('0);
      chk(trap_num_o == 7'h02, "R6 nmi first", int'(trap_num_o), 2);
      cyc('0, .ret(1)); cyc('0);
      chk(trap_take_o && trap_num_o == 7'h04, "R6 overflow second", int'(trap_num_o), 4);
      cyc('0, .ret(1)); cyc('0);
      chk(trap_take_o && trap_num_o == 7'h06, "R6 underflow third", int'(trap_num_o), 6);
      cyc('0, .ret(1)); idle(2);
      chk(flags_o == 11'h038, "R2 class-A flags", int'(flags_o), 'h38);

      // R3: clear one bit, keep the rest; set beats clear
      cyc('0, .wr(1), .wd(11'h030)); idle(1);
      chk(flags_o == 11'h030, "R3 selective clear", int'(flags_o), 'h30);
      cyc(11'h010, .wr(1), .wd('0)); idle(1);
      chk(flags_o[4] == 1'b1, "R3 set wins", int'(flags_o), 'h10);
      cyc('0, .ret(1)); idle(2);
      cyc('0, .ret(1)); cyc('0, .wr(1), .wd('0)); idle(1);

      // R7: two faults at once give one service
      cyc(11'h140); cyc('0);
      chk(trap_take_o && svc_lvl_o == 2'd1, "R7 one service", int'(svc_lvl_o), 1);
      idle(1);
      chk(!trap_take_o, "R7 no second service", int'(trap_take_o), 0);
      // R8: class A preempts class B; another fault waits
      cyc(11'h008); cyc('0);
      chk(trap_take_o && svc_lvl_o == 2'd2, "R8 preempt", int'(svc_lvl_o), 2);
      cyc(11'h080); cyc('0); idle(2);
      chk(!trap_take_o && svc_lvl_o == 2'd2, "R8 lower held", int'(svc_lvl_o), 2);
      // R11: software trap refused at nonzero level
      cyc('0, .sw(1), .swn(7'h33));
      chk(!trap_take_o && trap_num_o == 7'h02, "R11 refused at level", int'(trap_take_o), 0);
      cyc('0, .ret(1));
      chk(svc_lvl_o == 2'd1 && !trap_take_o, "R9 restore level", int'(svc_lvl_o), 1);
      idle(1);
      chk(!trap_take_o, "R8 equal level held", int'(trap_take_o), 0);
      cyc('0, .ret(1)); cyc('0);
      chk(trap_take_o && svc_lvl_o == 2'd1, "R8 held fault taken", int'(svc_lvl_o), 1);
      cyc('0, .ret(1)); cyc('0, .ret(1));
      chk(svc_lvl_o == 2'd0, "R9 return at idle", int'(svc_lvl_o), 0);
      // R11: accepted at level 0
      cyc('0, .sw(1), .swn(7'h7F));
      chk(trap_take_o && trap_vec_o == 24'h1FC && svc_lvl_o == 0, "R11 max number", int'(trap_vec_o), 'h1FC);
      cyc('0, .wr(1), .wd('0));

      for (int i = 0; i < 4000; i++) begin
         logic [10:0] s;
         s = '0;
         for (int j = 0; j < 11; j++) if ($urandom_range(59) == 0) s[j] = 1'b1;
         cyc(s, ($urandom_range(9) == 0), 7'($urandom), ($urandom_range(5) == 0),
             ($urandom_range(29) == 0), 11'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", n_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule